// File: doc/BRIEF.md
# Cache Victim Line Selector

This block decides which line of a small fully associative cache should be evicted when a new block has to be brought in. The cache controller reports every hit and every fill by line index, and it presents the current per-line valid and lock bits. It raises a request when it needs a victim. One cycle later the selector returns the chosen line index, or reports that no line can be replaced. The tag store and the data path stay outside this block.

Four replacement policies are selectable at run time through a two-bit mode input: least recently used, first in first out, least frequently used and pseudo-random. All four follow the same two rules. An empty, unlocked line is always taken first, lowest index first. A locked line is never returned. Internally the block keeps two recency orderings, one driven by every touch and one driven only by fills. It also keeps a saturating hit counter for each line and a free-running LFSR.

The response logic is a two-state machine. `ST_IDLE` means no answer is being presented. `ST_RESP` means an answer is on the outputs. The transition `req_seen` moves `ST_IDLE` to `ST_RESP` and also keeps the machine in `ST_RESP` when requests come back to back. The transition `req_quiet` moves `ST_RESP` back to `ST_IDLE` when no request is present.

Top module: `victim_selector`

## Requirements
- R1: `victim_valid` is high in exactly the cycles that follow a cycle with `req` high. The answer is computed from the tracking state and the inputs as they stood in the request cycle, so a hit or fill in that same cycle does not affect that answer.
- R2: A line whose `line_lock` bit is set is never returned. When every line is locked, `none_available` is high in the response and `victim_idx` is 0. Otherwise `none_available` is low.
- R3: In every mode, if any line is both invalid and unlocked, the lowest-indexed such line is returned.
- R4: Mode 0 (LRU) returns the valid, unlocked line that has gone longest without a hit or a fill. After reset, higher-indexed lines count as older than lower-indexed ones until they are touched.
- R5: Mode 1 (FIFO) returns the valid, unlocked line whose last fill is oldest. Hits leave this order unchanged, and the reset ordering is the same as in R4.
- R6: Mode 2 (LFU) returns the valid, unlocked line with the smallest hit count. Equal counts go to the lowest index.
- R7: Each hit counter is 4 bits wide and stops at 15. A fill of a line clears that line's counter to 0.
- R8: Mode 3 (random) uses a 16-bit Galois LFSR. The LFSR is seeded with 0xACE1 during reset and steps on every clock edge after reset: it shifts right and, when the bit shifted out is 1, XORs in 0xB400. The low three bits of the LFSR in the request cycle give a start index. The first unlocked line from that index upward, wrapping past 7 to 0, is returned.
- R9: When `hit_valid` and `fill_valid` are both high in one cycle, only the fill takes effect. The hit changes neither the recency order nor any counter.
- R10: The mode encoding is 0 for LRU, 1 for FIFO, 2 for LFU and 3 for random. Mode is sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Replacement policy select |
| hit_valid | input | 1 | A hit occurred this cycle |
| hit_idx | input | 3 | Line that hit |
| fill_valid | input | 1 | A line is being filled this cycle |
| fill_idx | input | 3 | Line being filled |
| line_valid | input | 8 | Per-line valid bits |
| line_lock | input | 8 | Per-line lock bits |
| req | input | 1 | Request for a victim |
| victim_valid | output | 1 | Response present |
| victim_idx | output | 3 | Chosen line |
| none_available | output | 1 | Every line is locked |

## Verification
The bench targets the following corner cases, each paired with the wrong outcome it would expose:
- A locked line that would otherwise be the oldest or least used. A design that skips masking would return it.
- All lines locked. A design that gets this wrong would hand out a stale index with `none_available` low.
- A hit arriving together with a fill. A design that still applied the hit would shift the LRU order and the counter values.
- A counter driven well past 15. A design that wrapped instead of saturating would suddenly treat a heavily used line as the least used.
- Hits in FIFO mode. A design that applied them there would change the FIFO victim.
- A random start that falls on a locked line. A design that did not wrap its scan would return a locked line or an index out of order.

// File: rtl/vs_pkg.sv
package vs_pkg;
    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_LFU  = 2'd2,
        POL_RAND = 2'd3
    } policy_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/vs_rank_tracker.sv
module vs_rank_tracker #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            touch,
    input  logic [IDX_W-1:0]                touch_idx,
    output logic [N_LINES-1:0][IDX_W-1:0]   rank_o
);
    logic [N_LINES-1:0][IDX_W-1:0] rank_q;
    logic [IDX_W-1:0]              touched_rank;

    assign touched_rank = rank_q[touch_idx];
    assign rank_o       = rank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINES; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int j = 0; j < N_LINES; j++) begin
                if (IDX_W'(j) == touch_idx)
                    rank_q[j] <= '0;
                else if (rank_q[j] < touched_rank)
                    rank_q[j] <= rank_q[j] + 1'b1;
            end
        end
    end

    logic [N_LINES-1:0] occupied;
    always_comb begin
        occupied = '0;
        for (int i = 0; i < N_LINES; i++) occupied[rank_q[i]] = 1'b1;
    end

    // R4 / R5: the ages always form a permutation of 0..N-1
    a_r4_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        occupied == '1);

    // R4 / R5: a touched line becomes the youngest
    a_r5_touch_youngest: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/vs_lfu_counters.sv
module vs_lfu_counters #(
    parameter int N_LINES = 8,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hit_en,
    input  logic [IDX_W-1:0]                hit_idx,
    input  logic                            fill_en,
    input  logic [IDX_W-1:0]                fill_idx,
    output logic [N_LINES-1:0][CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N_LINES-1:0][CNT_W-1:0] cnt_q;
    assign cnt_o = cnt_q;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (fill_en && fill_idx == IDX_W'(g))
                cnt_q[g] <= '0;
            else if (hit_en && hit_idx == IDX_W'(g) && cnt_q[g] != CNT_MAX)
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        // R7: a saturated counter stays saturated under further hits
        a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_en && hit_idx == IDX_W'(g) && !fill_en && cnt_q[g] == CNT_MAX)
            |=> cnt_q[g] == CNT_MAX);

        // R7: a fill clears the counter
        a_r7_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && fill_idx == IDX_W'(g)) |=> cnt_q[g] == '0);
    end
endmodule

// File: rtl/vs_lfsr.sv
module vs_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);
    logic [W-1:0] lfsr_q;
    assign state_o = lfsr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else
            lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
    end

    // R8: the generator never locks up at zero
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/victim_selector.sv
module victim_selector
    import vs_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int CNT_W   = 4,
    parameter int LFSR_W  = 16,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               hit_valid,
    input  logic [IDX_W-1:0]   hit_idx,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [N_LINES-1:0] line_valid,
    input  logic [N_LINES-1:0] line_lock,
    input  logic               req,
    output logic               victim_valid,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               none_available
);
    // R9: a fill in the same cycle suppresses the hit
    logic hit_eff;
    assign hit_eff = hit_valid && !fill_valid;

    logic [N_LINES-1:0][IDX_W-1:0] lru_rank;
    logic [N_LINES-1:0][IDX_W-1:0] fifo_rank;
    logic [N_LINES-1:0][CNT_W-1:0] use_cnt;
    logic [LFSR_W-1:0]             lfsr;

    vs_rank_tracker #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch(hit_eff || fill_valid),
        .touch_idx(fill_valid ? fill_idx : hit_idx),
        .rank_o(lru_rank)
    );

    vs_rank_tracker #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .touch(fill_valid), .touch_idx(fill_idx),
        .rank_o(fifo_rank)
    );

    vs_lfu_counters #(.N_LINES(N_LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lfu (
        .clk(clk), .rst_n(rst_n),
        .hit_en(hit_eff), .hit_idx(hit_idx),
        .fill_en(fill_valid), .fill_idx(fill_idx),
        .cnt_o(use_cnt)
    );

    vs_lfsr #(.W(LFSR_W)) u_rng (.clk(clk), .rst_n(rst_n), .state_o(lfsr));

    // ---------------- selection network ----------------
    logic [N_LINES-1:0] unlocked, free_lines, cand;
    assign unlocked   = ~line_lock;
    assign free_lines = ~line_valid & unlocked;
    assign cand       = line_valid & unlocked;

    logic [IDX_W-1:0] free_pick, lru_pick, fifo_pick, lfu_pick, rand_pick, sel_idx;
    logic             sel_none;

    always_comb begin
        free_pick = '0;
        for (int i = N_LINES - 1; i >= 0; i--)
            if (free_lines[i]) free_pick = IDX_W'(i);
    end

    always_comb begin
        logic             f_l, f_f, f_u;
        logic [IDX_W-1:0] best_l, best_f;
        logic [CNT_W-1:0] best_u;
        f_l = 1'b0; f_f = 1'b0; f_u = 1'b0;
        best_l = '0; best_f = '0; best_u = '0;
        lru_pick = '0; fifo_pick = '0; lfu_pick = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (cand[i]) begin
                if (!f_l || lru_rank[i] > best_l) begin
                    f_l = 1'b1; best_l = lru_rank[i]; lru_pick = IDX_W'(i);
                end
                if (!f_f || fifo_rank[i] > best_f) begin
                    f_f = 1'b1; best_f = fifo_rank[i]; fifo_pick = IDX_W'(i);
                end
                if (!f_u || use_cnt[i] < best_u) begin
                    f_u = 1'b1; best_u = use_cnt[i]; lfu_pick = IDX_W'(i);
                end
            end
        end
    end

    always_comb begin
        int start;
        start     = int'(lfsr[IDX_W-1:0]);
        rand_pick = '0;
        for (int k = N_LINES - 1; k >= 0; k--)
            if (unlocked[(start + k) % N_LINES]) rand_pick = IDX_W'((start + k) % N_LINES);
    end

    always_comb begin
        sel_none = ~|unlocked;
        if (sel_none)
            sel_idx = '0;
        else if (|free_lines)
            sel_idx = free_pick;
        else begin
            unique case (policy_e'(mode))
                POL_LRU:  sel_idx = lru_pick;
                POL_FIFO: sel_idx = fifo_pick;
                POL_LFU:  sel_idx = lfu_pick;
                POL_RAND: sel_idx = rand_pick;
                default:  sel_idx = '0;
            endcase
        end
    end

    // ---------------- response state machine ----------------
    resp_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             none_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_RESP : ST_IDLE;   // req_seen
            ST_RESP: state_d = req ? ST_RESP : ST_IDLE;   // req_seen / req_quiet
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            none_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req) begin
                idx_q  <= sel_idx;
                none_q <= sel_none;
            end
        end
    end

    always_comb begin
        victim_valid   = (state_q == ST_RESP);
        victim_idx     = victim_valid ? idx_q : '0;
        none_available = victim_valid && none_q;
    end

    // R1: a response follows each request, and only a request
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (victim_valid == $past(req)));

    // R2: a returned line was not locked in the request cycle
    a_r2_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !none_available) |->
            (($past(line_lock) & (N_LINES'(1) << victim_idx)) == '0));

    // R2: none_available exactly when all lines were locked
    a_r2_none_when_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (none_available == ($past(line_lock) == '1)));

    // R3: with a free unlocked line present, the answer is an invalid line
    a_r3_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && $past(|(~line_valid & ~line_lock))) |->
            (($past(line_valid) & (N_LINES'(1) << victim_idx)) == '0));
endmodule

// File: tb/tb_victim_selector.sv
module tb_victim_selector;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic       hit_valid = 1'b0, fill_valid = 1'b0, req = 1'b0;
    logic [2:0] hit_idx = '0, fill_idx = '0;
    logic [N-1:0] line_valid = '0, line_lock = '0;
    logic       victim_valid, none_available;
    logic [2:0] victim_idx;

    always #5 clk = ~clk;

    victim_selector dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .hit_valid(hit_valid), .hit_idx(hit_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .line_valid(line_valid), .line_lock(line_lock),
        .req(req), .victim_valid(victim_valid),
        .victim_idx(victim_idx), .none_available(none_available)
    );

    int checks = 0, fails = 0;

    // reference state
    int m_lru[N], m_fifo[N], m_cnt[N];
    logic [15:0] m_lfsr;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin m_lru[i] = i; m_fifo[i] = i; m_cnt[i] = 0; end
        m_lfsr = 16'hACE1;
    endfunction

    function automatic void touch(ref int r[N], input int k);
        int rk = r[k];
        for (int j = 0; j < N; j++)
            if (j == k) r[j] = 0; else if (r[j] < rk) r[j] = r[j] + 1;
    endfunction

    // expected victim from requirements R2..R8, R10
    function automatic int expect_idx(output int none, output string tag);
        int best = -1;
        none = (line_lock == '1);
        tag = "R2";
        if (none) return 0;
        for (int i = 0; i < N; i++)
            if (!line_valid[i] && !line_lock[i]) begin tag = "R3"; return i; end
        for (int i = 0; i < N; i++) begin
            if (line_lock[i]) continue;
            case (mode)
                2'd0: if (best < 0 || m_lru[i]  > m_lru[best])  best = i;
                2'd1: if (best < 0 || m_fifo[i] > m_fifo[best]) best = i;
                2'd2: if (best < 0 || m_cnt[i]  < m_cnt[best])  best = i;
                default: ;
            endcase
        end
        case (mode)
            2'd0: tag = "R4";
            2'd1: tag = "R5";
            2'd2: tag = "R6";
            default: begin
                tag = "R8";
                for (int k = N - 1; k >= 0; k--)
                    if (!line_lock[(int'(m_lfsr[2:0]) + k) % N]) best = (int'(m_lfsr[2:0]) + k) % N;
            end
        endcase
        return best;
    endfunction

    function automatic void model_step();
        if (fill_valid) begin          // R9: fill wins
            touch(m_lru, int'(fill_idx));
            touch(m_fifo, int'(fill_idx));
            m_cnt[fill_idx] = 0;
        end else if (hit_valid) begin
            touch(m_lru, int'(hit_idx));
            if (m_cnt[hit_idx] < 15) m_cnt[hit_idx] = m_cnt[hit_idx] + 1;
        end
        m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
    endfunction

    // one clock: inputs already driven at a negedge; check at next negedge
    task automatic cycle();
        int en, ei; string et; logic rq;
        rq = req;
        ei = expect_idx(en, et);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R1 victim_valid", int'(victim_valid), int'(rq));
        if (rq) begin
            check({et, " victim_idx"}, int'(victim_idx), ei);
            check("R2 none_available", int'(none_available), en);
        end
    endtask

    task automatic drive(int m, bit hv, int hi, bit fv, int fi, bit rq);
        mode = 2'(m); hit_valid = hv; hit_idx = 3'(hi);
        fill_valid = fv; fill_idx = 3'(fi); req = rq;
        cycle();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1: reset state
        check("R1 reset victim_valid", int'(victim_valid), 0);

        // R3: empty cache, lowest unlocked invalid line
        drive(0, 0, 0, 0, 0, 1);
        line_lock = 8'b0000_0011;
        drive(2, 0, 0, 0, 0, 1);
        line_lock = '0;

        // fill in order, then all valid
        for (int i = 0; i < N; i++) drive(0, 0, 0, 1, i, 0);
        line_valid = '1;
        drive(0, 0, 0, 0, 0, 1);   // R4 oldest fill
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 1, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1);   // R4 after hits
        drive(1, 0, 0, 0, 0, 1);   // R5 hits ignored
        line_lock = 8'b0000_0100;
        drive(0, 0, 0, 0, 0, 1);   // R2 masked LRU
        // R7 saturation
        for (int i = 0; i < 20; i++) drive(2, 1, 3, 0, 0, 0);
        drive(2, 0, 0, 0, 0, 1);   // R6
        // R9 simultaneous hit and fill
        drive(2, 1, 5, 1, 3, 1);
        drive(0, 0, 0, 0, 0, 1);
        drive(2, 0, 0, 0, 0, 1);   // R7 fill cleared line 3
        // R2 all locked
        line_lock = '1;
        drive(1, 0, 0, 0, 0, 1);
        // R8 random with locks
        line_lock = 8'b1010_1010;
        for (int i = 0; i < 6; i++) drive(3, 0, 0, 0, 0, 1);
        line_lock = '0;

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            line_valid = ($urandom % 4 == 0) ? 8'($urandom) : '1;
            line_lock  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            drive(int'($urandom % 4), ($urandom % 2) == 1, int'($urandom % 8),
                  ($urandom % 4) == 0, int'($urandom % 8), ($urandom % 3) != 0);
        end
        req = 1'b0; hit_valid = 1'b0; fill_valid = 1'b0;
        cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule